// File: doc/BRIEF.md
# MCMC Row Sampler with Rejection Counters

This block drives a Markov chain Monte Carlo walk that fills a sample store one row at a time. Each row holds one model of `NPARAM` signed parameters. Sampling starts when a start strobe loads the caller's initial model into row 0. From then on, the controller builds a candidate by adding a roughly bell-shaped random offset to every parameter of the current row. It presents the candidate on an output bus and then waits for an outside judge to accept or reject it.

A reject leaves the chain on the same row and adds one to that row's counter, so the counter records how many times the row's sample was kept. That count is the row's weight in the posterior estimate. An accept writes the candidate into the next row, gives that row a count of one, and moves the chain forward. When the final row has been written, the block stops and raises `done`. A combinational read port lets the caller fetch any row's sample and count at any time.

Top module: `mcmc_row_sampler`

## Requirements
- R1: After a synchronous active-low reset, `prop_valid`, `done` and `cur_row` are 0, and every row reads back a sample of 0 and a count of 0.
- R2: A `start` pulse while idle or done does four things: it writes `init_sample` into row 0, sets row 0's count to 1, clears every other row's count to 0 and sets `cur_row` to 0. A first candidate follows two cycles later.
- R3: Each lane of a candidate equals the current row's lane plus a random offset in [-26, 30], saturated to [-128, 127]. The offset is the sum of four 4-bit LFSR values, each in 1..15, minus 30. Successive candidates drawn from the same row differ. Lane i occupies bits [8i+7:8i] of every sample bus.
- R4: While `prop_valid` is high and no decision has arrived, `prop_data` holds steady and `prop_valid` stays high.
- R5: A reject (`dec_valid` with `dec_accept`=0) adds 1 to the current row's count and keeps `cur_row` unchanged. The next candidate is again drawn around that row.
- R6: An accept writes the candidate into row `cur_row`+1, sets that row's count to 1 and advances `cur_row`. The next candidate is drawn around the new row.
- R7: A count that has reached its maximum, 2^CNT_W-1 (65535 by default), stays there on further rejects.
- R8: Once row `NROWS`-1 has been written, `done` is high and `prop_valid` is low. Decision strobes then change nothing.
- R9: A decision strobe while `prop_valid` is low is ignored. A `start` pulse while the chain is sampling is ignored, even when it arrives in the same cycle as a decision, which still takes effect.
- R10: `rd_sample` and `rd_count` show the sample and count of row `rd_row` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Load the initial sample into row 0 and begin sampling |
| init_sample | input | NPARAM*PW | Initial model, lane i at bits [PW*i+PW-1:PW*i] |
| prop_valid | output | 1 | Candidate on `prop_data` awaits a decision |
| prop_data | output | NPARAM*PW | Candidate model |
| dec_valid | input | 1 | Decision strobe |
| dec_accept | input | 1 | 1 = accept, 0 = reject; read when `dec_valid` is high |
| cur_row | output | log2(NROWS) | Row the chain currently stands on |
| done | output | 1 | Last row has been filled |
| rd_row | input | log2(NROWS) | Row selected for read-back |
| rd_sample | output | NPARAM*PW | Sample stored in row `rd_row` |
| rd_count | output | CNT_W | Count of row `rd_row` |

## Verification
A restart request and a decision can land on the same clock edge while a candidate is pending. The bench raises `start` together with a reject strobe and then judges the outcome on the read port and `cur_row`: the current row's count must have risen by one, and row 0 and the chain position must be left as they were. The bench also keeps a decision strobe high for one extra cycle, so that it overlaps the cycle in which the next candidate is formed. Its check is that only one count step results.

// File: rtl/mcmc_pkg.sv
// Package: shared state encoding and LFSR helpers for the MCMC row sampler.
// Assumes LFSR widths between 3 and 8 bits.
package mcmc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PROPOSE = 2'd1,
        ST_WAIT    = 2'd2,
        ST_DONE    = 2'd3
    } chain_state_t;

    // Galois feedback mask giving a maximal-length sequence for width w.
    function automatic logic [7:0] galois_mask(input int w);
        case (w)
            3:       return 8'h06;
            4:       return 8'h0C;
            5:       return 8'h14;
            6:       return 8'h30;
            7:       return 8'h60;
            default: return 8'hB8;
        endcase
    endfunction

    // Non-zero start value that spreads generator phases apart.
    function automatic int lfsr_seed(input int idx, input int w);
        return ((idx * 7) % ((1 << w) - 1)) + 1;
    endfunction

endpackage

// File: rtl/mcmc_noise_gen.sv
// Module: mcmc_noise_gen
// Produces one near-Gaussian signed offset per parameter lane. Each offset is
// the sum of NTAP small LFSRs minus the sum's midpoint. All generators advance
// together when step is high.
// Assumes OUT_W is wide enough for the centred sum.
module mcmc_noise_gen
    import mcmc_pkg::*;
#(
    parameter int NPARAM = 4,
    parameter int LFSR_W = 4,
    parameter int NTAP   = 4,
    parameter int OUT_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     step,
    output logic [NPARAM*OUT_W-1:0]  noise_flat
);

    localparam int NLFSR = NPARAM * NTAP;
    localparam int LMAX  = (1 << LFSR_W) - 1;
    localparam int SUM_W = LFSR_W + $clog2(NTAP) + 1;
    localparam int OFS   = (NTAP * LMAX) / 2;
    localparam int NMIN  = NTAP - OFS;
    localparam int NMAX  = NTAP * LMAX - OFS;
    localparam logic [LFSR_W-1:0] MASK = LFSR_W'(galois_mask(LFSR_W));

    logic [LFSR_W-1:0] lfsr_q [NLFSR];

    genvar g;
    generate
        for (g = 0; g < NLFSR; g++) begin : g_lfsr
            // Advance one Galois generator whenever a new draw is consumed.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    lfsr_q[g] <= LFSR_W'(lfsr_seed(g, LFSR_W));
                else if (step)
                    lfsr_q[g] <= lfsr_q[g][0] ? ((lfsr_q[g] >> 1) ^ MASK)
                                              : (lfsr_q[g] >> 1);
            end
        end

        for (g = 0; g < NPARAM; g++) begin : g_lane
            logic [SUM_W-1:0]      tap_sum;
            logic signed [SUM_W:0] centred;

            // Add the lane's generators together.
            always_comb begin
                tap_sum = '0;
                for (int t = 0; t < NTAP; t++)
                    tap_sum = tap_sum + SUM_W'(lfsr_q[g*NTAP + t]);
            end

            assign centred = $signed({1'b0, tap_sum}) - $signed((SUM_W+1)'(OFS));
            assign noise_flat[g*OUT_W +: OUT_W] = OUT_W'(centred);

            // R3: every generator stays non-zero, so the offset keeps its range.
            p_noise_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (centred >= NMIN) && (centred <= NMAX))
                else $error("noise lane %0d out of range", g);
        end
    endgenerate

endmodule

// File: rtl/mcmc_proposer.sv
// Module: mcmc_proposer
// Combinational candidate builder. It adds each lane's offset to the current
// row's lane and clamps the result to the signed PW-bit range.
// Assumes the offsets are PW-bit two's complement values.
module mcmc_proposer #(
    parameter int NPARAM = 4,
    parameter int PW     = 8
) (
    input  logic [NPARAM*PW-1:0] base_flat,
    input  logic [NPARAM*PW-1:0] noise_flat,
    output logic [NPARAM*PW-1:0] prop_flat
);

    localparam logic signed [PW:0] HI = (PW+1)'((1 << (PW-1)) - 1);
    localparam logic signed [PW:0] LO = (PW+1)'(-(1 << (PW-1)));

    genvar l;
    generate
        for (l = 0; l < NPARAM; l++) begin : g_lane
            logic [PW-1:0]      b;
            logic [PW-1:0]      n;
            logic signed [PW:0] wide;

            assign b    = base_flat[l*PW +: PW];
            assign n    = noise_flat[l*PW +: PW];
            assign wide = $signed({b[PW-1], b}) + $signed({n[PW-1], n});

            // Clamp the widened sum back into the lane width.
            always_comb begin
                if (wide > HI)
                    prop_flat[l*PW +: PW] = HI[PW-1:0];
                else if (wide < LO)
                    prop_flat[l*PW +: PW] = LO[PW-1:0];
                else
                    prop_flat[l*PW +: PW] = wide[PW-1:0];
            end
        end
    endgenerate

endmodule

// File: rtl/mcmc_sample_store.sv
// Module: mcmc_sample_store
// Row storage for samples and their rejection counters. A sample write also
// sets that row's count to 1. clr_all clears every count, and a write in the
// same cycle takes precedence. Counts saturate when incremented. Port A feeds
// the proposer and port B feeds the external read-back.
// Assumes the controller never increments a row that it writes in the same cycle.
module mcmc_sample_store #(
    parameter int NROWS  = 64,
    parameter int WORD_W = 32,
    parameter int CNT_W  = 16,
    parameter int RW     = $clog2(NROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_all,
    input  logic              wr_en,
    input  logic [RW-1:0]     wr_row,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              inc_en,
    input  logic [RW-1:0]     inc_row,
    input  logic [RW-1:0]     a_row,
    output logic [WORD_W-1:0] a_data,
    input  logic [RW-1:0]     b_row,
    output logic [WORD_W-1:0] b_data,
    output logic [CNT_W-1:0]  b_cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [WORD_W-1:0] smp_q [NROWS];
    logic [CNT_W-1:0]  cnt_q [NROWS];
    logic [CNT_W-1:0]  inc_cnt_now;

    // Sample rows: cleared at reset, written on start or accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NROWS; r++)
                smp_q[r] <= '0;
        end else if (wr_en) begin
            smp_q[wr_row] <= wr_data;
        end
    end

    genvar r;
    generate
        for (r = 0; r < NROWS; r++) begin : g_cnt
            // Per-row counter: set on write, cleared on restart, saturating step on reject.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cnt_q[r] <= '0;
                else if (wr_en && (wr_row == RW'(r)))
                    cnt_q[r] <= CNT_ONE;
                else if (clr_all)
                    cnt_q[r] <= '0;
                else if (inc_en && (inc_row == RW'(r)) && (cnt_q[r] != CNT_MAX))
                    cnt_q[r] <= cnt_q[r] + CNT_ONE;
            end
        end
    endgenerate

    assign a_data      = smp_q[a_row];
    assign b_data      = smp_q[b_row];
    assign b_cnt       = cnt_q[b_row];
    assign inc_cnt_now = cnt_q[inc_row];

    // R5: a reject on an unsaturated row raises its count by exactly one.
    p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_en && !wr_en && !clr_all && (inc_cnt_now != CNT_MAX))
        |=> (cnt_q[$past(inc_row)] == $past(inc_cnt_now) + CNT_ONE))
        else $error("count did not step by one");

    // R7: a saturated count stays at its maximum on a reject.
    p_cnt_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_en && !wr_en && !clr_all && (inc_cnt_now == CNT_MAX))
        |=> (cnt_q[$past(inc_row)] == CNT_MAX))
        else $error("saturated count moved");

endmodule

// File: rtl/mcmc_chain_ctrl.sv
// Module: mcmc_chain_ctrl
// Chain sequencer. On start it loads row 0. It then latches a candidate,
// waits for an accept/reject decision and either steps the current row's
// count or writes the candidate one row further on. It stops after the last row.
// Assumes NROWS >= 2 and that cand reflects the store's current row combinationally.
module mcmc_chain_ctrl
    import mcmc_pkg::*;
#(
    parameter int NPARAM = 4,
    parameter int PW     = 8,
    parameter int NROWS  = 64,
    parameter int RW     = $clog2(NROWS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [NPARAM*PW-1:0] init_sample,
    input  logic                 dec_valid,
    input  logic                 dec_accept,
    input  logic [NPARAM*PW-1:0] cand,
    output logic                 prop_valid,
    output logic [NPARAM*PW-1:0] prop_data,
    output logic [RW-1:0]        cur_row,
    output logic                 done,
    output logic                 noise_step,
    output logic                 clr_all,
    output logic                 wr_en,
    output logic [RW-1:0]        wr_row,
    output logic [NPARAM*PW-1:0] wr_data,
    output logic                 inc_en,
    output logic [RW-1:0]        inc_row
);

    localparam logic [RW-1:0] LAST_ROW = RW'(NROWS - 1);
    localparam logic [RW-1:0] ROW_ONE  = RW'(1);

    chain_state_t         state_q;
    logic [RW-1:0]        row_q;
    logic [NPARAM*PW-1:0] prop_q;
    logic                 restart;
    logic                 take_dec;

    assign restart  = start && ((state_q == ST_IDLE) || (state_q == ST_DONE));
    assign take_dec = dec_valid && (state_q == ST_WAIT);

    // Store and generator commands for the present cycle.
    always_comb begin
        clr_all    = 1'b0;
        wr_en      = 1'b0;
        wr_row     = '0;
        wr_data    = init_sample;
        inc_en     = 1'b0;
        inc_row    = row_q;
        noise_step = (state_q == ST_PROPOSE);
        if (restart) begin
            clr_all = 1'b1;
            wr_en   = 1'b1;
        end else if (take_dec) begin
            if (dec_accept) begin
                wr_en   = 1'b1;
                wr_row  = row_q + ROW_ONE;
                wr_data = prop_q;
            end else begin
                inc_en = 1'b1;
            end
        end
    end

    // Sequencer state, chain position and latched candidate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            row_q   <= '0;
            prop_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (restart) begin
                        row_q   <= '0;
                        state_q <= ST_PROPOSE;
                    end
                end
                ST_PROPOSE: begin
                    prop_q  <= cand;
                    state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (take_dec) begin
                        if (dec_accept) begin
                            row_q   <= row_q + ROW_ONE;
                            state_q <= ((row_q + ROW_ONE) == LAST_ROW) ? ST_DONE : ST_PROPOSE;
                        end else begin
                            state_q <= ST_PROPOSE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign prop_valid = (state_q == ST_WAIT);
    assign prop_data  = prop_q;
    assign cur_row    = row_q;
    assign done       = (state_q == ST_DONE);

    // R4: an undecided candidate is held steady and stays valid.
    p_prop_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (prop_valid && !dec_valid) |=> (prop_valid && $stable(prop_data)))
        else $error("candidate changed while waiting");

    // R5: a reject keeps the chain on its row.
    p_row_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (prop_valid && dec_valid && !dec_accept) |=> (cur_row == $past(cur_row)))
        else $error("row moved on reject");

    // R6: an accept advances the chain by exactly one row.
    p_row_adv_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (prop_valid && dec_valid && dec_accept) |=> (cur_row == $past(cur_row) + ROW_ONE))
        else $error("row did not advance on accept");

    // R8: after completion, decision strobes leave the position and flag alone.
    p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && dec_valid && !start) |=> (done && $stable(cur_row) && !prop_valid))
        else $error("done state disturbed by decision");

endmodule

// File: rtl/mcmc_row_sampler.sv
// Module: mcmc_row_sampler (top)
// Builds an MCMC sample set row by row, with one saturating rejection counter
// per row. The caller supplies the accept/reject decisions and reads the rows
// back through a combinational port.
// Assumes NROWS is a power of two and at least 2.
module mcmc_row_sampler #(
    parameter int NPARAM = 4,
    parameter int PW     = 8,
    parameter int NROWS  = 64,
    parameter int CNT_W  = 16,
    parameter int LFSR_W = 4,
    parameter int NTAP   = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [NPARAM*PW-1:0]        init_sample,
    output logic                        prop_valid,
    output logic [NPARAM*PW-1:0]        prop_data,
    input  logic                        dec_valid,
    input  logic                        dec_accept,
    output logic [$clog2(NROWS)-1:0]    cur_row,
    output logic                        done,
    input  logic [$clog2(NROWS)-1:0]    rd_row,
    output logic [NPARAM*PW-1:0]        rd_sample,
    output logic [CNT_W-1:0]            rd_count
);

    localparam int RW     = $clog2(NROWS);
    localparam int WORD_W = NPARAM * PW;

    logic              noise_step;
    logic [WORD_W-1:0] noise_flat;
    logic [WORD_W-1:0] base_flat;
    logic [WORD_W-1:0] cand;
    logic              clr_all;
    logic              wr_en;
    logic [RW-1:0]     wr_row;
    logic [WORD_W-1:0] wr_data;
    logic              inc_en;
    logic [RW-1:0]     inc_row;

    mcmc_noise_gen #(
        .NPARAM (NPARAM),
        .LFSR_W (LFSR_W),
        .NTAP   (NTAP),
        .OUT_W  (PW)
    ) u_noise (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (noise_step),
        .noise_flat (noise_flat)
    );

    mcmc_proposer #(
        .NPARAM (NPARAM),
        .PW     (PW)
    ) u_prop (
        .base_flat  (base_flat),
        .noise_flat (noise_flat),
        .prop_flat  (cand)
    );

    mcmc_sample_store #(
        .NROWS  (NROWS),
        .WORD_W (WORD_W),
        .CNT_W  (CNT_W),
        .RW     (RW)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_all (clr_all),
        .wr_en   (wr_en),
        .wr_row  (wr_row),
        .wr_data (wr_data),
        .inc_en  (inc_en),
        .inc_row (inc_row),
        .a_row   (cur_row),
        .a_data  (base_flat),
        .b_row   (rd_row),
        .b_data  (rd_sample),
        .b_cnt   (rd_count)
    );

    mcmc_chain_ctrl #(
        .NPARAM (NPARAM),
        .PW     (PW),
        .NROWS  (NROWS),
        .RW     (RW)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .init_sample (init_sample),
        .dec_valid   (dec_valid),
        .dec_accept  (dec_accept),
        .cand        (cand),
        .prop_valid  (prop_valid),
        .prop_data   (prop_data),
        .cur_row     (cur_row),
        .done        (done),
        .noise_step  (noise_step),
        .clr_all     (clr_all),
        .wr_en       (wr_en),
        .wr_row      (wr_row),
        .wr_data     (wr_data),
        .inc_en      (inc_en),
        .inc_row     (inc_row)
    );

endmodule

// File: tb/sim_mcmc_row_sampler.sv
// Scoreboard bench: the driver updates a reference model and queues expected
// rows; the monitor reads each queued row back through the read port.
module sim_mcmc_row_sampler;

    localparam int NP   = 4;
    localparam int PW   = 8;
    localparam int NR   = 16;
    localparam int CW   = 6;
    localparam int RW   = $clog2(NR);
    localparam int SW   = NP * PW;
    localparam int CMAX = (1 << CW) - 1;
    localparam int NLO  = -26;
    localparam int NHI  = 30;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [SW-1:0] init_sample = '0;
    logic          prop_valid;
    logic [SW-1:0] prop_data;
    logic          dec_valid = 1'b0;
    logic          dec_accept = 1'b0;
    logic [RW-1:0] cur_row;
    logic          done;
    logic [RW-1:0] rd_row = '0;
    logic [SW-1:0] rd_sample;
    logic [CW-1:0] rd_count;

    always #4 clk = ~clk;

    mcmc_row_sampler #(
        .NPARAM (NP), .PW (PW), .NROWS (NR), .CNT_W (CW), .LFSR_W (4), .NTAP (4)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .start (start), .init_sample (init_sample),
        .prop_valid (prop_valid), .prop_data (prop_data),
        .dec_valid (dec_valid), .dec_accept (dec_accept),
        .cur_row (cur_row), .done (done),
        .rd_row (rd_row), .rd_sample (rd_sample), .rd_count (rd_count)
    );

    typedef struct {
        int            row;
        logic [SW-1:0] smp;
        int            cnt;
        string         req;
    } sb_item_t;

    sb_item_t      sb_q[$];
    bit            mon_busy = 0;
    int            n_chk = 0;
    int            n_fail = 0;
    bit            finished = 0;
    logic [SW-1:0] m_smp [NR];
    int            m_cnt [NR];
    int            m_cur = 0;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input string what, input int act, input int lo, input int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=[%0d,%0d]", req, what, act, lo, hi);
        end
    endtask

    function automatic int lane(input logic [SW-1:0] v, input int i);
        return int'($signed(v[i*PW +: PW]));
    endfunction

    task automatic push(input int row, input string req);
        sb_q.push_back('{row, m_smp[row], m_cnt[row], req});
    endtask

    task automatic drain();
        wait (sb_q.size() == 0 && mon_busy == 0);
        @(negedge clk);
    endtask

    // Monitor: read each expected row through the port and compare (R10).
    initial begin
        forever begin
            sb_item_t it;
            wait (sb_q.size() != 0);
            mon_busy = 1;
            it = sb_q.pop_front();
            rd_row = RW'(it.row);
            #1;
            chk({it.req, "/R10"}, $sformatf("row %0d sample", it.row), longint'(rd_sample), longint'(it.smp));
            chk({it.req, "/R10"}, $sformatf("row %0d count", it.row), longint'(rd_count), longint'(it.cnt));
            mon_busy = 0;
        end
    end

    task automatic do_start(input logic [SW-1:0] v);
        init_sample = v;
        start = 1;
        @(negedge clk);
        start = 0;
        for (int r = 0; r < NR; r++) m_cnt[r] = 0;
        m_smp[0] = v;
        m_cnt[0] = 1;
        m_cur = 0;
        chk("R2", "cur_row after start", cur_row, 0);
        chk("R2", "done after start", done, 0);
        for (int r = 0; r < NR; r++) push(r, "R2");
        drain();
    endtask

    // Driver: wait for a candidate, check it, decide, then queue expectations.
    task automatic step(input bit acc, input int hold, input bit stretch, input bit with_start,
                        output logic [SW-1:0] got);
        while (!prop_valid) @(negedge clk);
        got = prop_data;
        for (int i = 0; i < NP; i++) begin
            int c = lane(m_smp[m_cur], i);
            int lo = (c + NLO < -128) ? -128 : c + NLO;
            int hi = (c + NHI > 127) ? 127 : c + NHI;
            chk_rng("R3", $sformatf("lane %0d around row %0d", i, m_cur), lane(got, i), lo, hi);
        end
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk("R4", "valid held", prop_valid, 1);
            chk("R4", "candidate stable", longint'(prop_data), longint'(got));
        end
        dec_valid = 1;
        dec_accept = acc;
        start = with_start;
        @(negedge clk);
        start = 0;
        if (stretch) @(negedge clk);
        dec_valid = 0;
        dec_accept = 0;
        if (acc) begin
            m_cur++;
            m_smp[m_cur] = got;
            m_cnt[m_cur] = 1;
            push(m_cur, stretch ? "R6/R9" : "R6");
        end else begin
            if (m_cnt[m_cur] == CMAX) push(m_cur, "R7");
            m_cnt[m_cur] = (m_cnt[m_cur] < CMAX) ? m_cnt[m_cur] + 1 : CMAX;
            push(m_cur, stretch ? "R5/R9" : "R5");
        end
        if (with_start) begin
            push(0, "R9");
            chk("R9", "row kept under start", cur_row, m_cur);
        end
        chk("R5/R6", "cur_row", cur_row, m_cur);
        chk("R8", "done flag", done, (m_cur == NR - 1) ? 1 : 0);
        drain();
    endtask

    initial begin
        logic [SW-1:0] got;
        int draws [6];
        int distinct;
        for (int r = 0; r < NR; r++) begin m_smp[r] = '0; m_cnt[r] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk("R1", "prop_valid after reset", prop_valid, 0);
        chk("R1", "done after reset", done, 0);
        chk("R1", "cur_row after reset", cur_row, 0);
        for (int r = 0; r < NR; r++) push(r, "R1");
        drain();

        // Lanes: 0 = 127, 1 = -128, 2 = 0, 3 = 50 (saturation at both ends).
        do_start({8'd50, 8'd0, 8'h80, 8'h7F});
        step(0, 3, 0, 0, got);
        for (int k = 0; k < 6; k++) begin
            step(0, 0, 0, 0, got);
            draws[k] = lane(got, 2);
        end
        distinct = 0;
        for (int k = 1; k < 6; k++) if (draws[k] != draws[0]) distinct++;
        chk("R3", "draws from one row vary", (distinct > 0) ? 1 : 0, 1);
        step(1, 0, 0, 0, got);
        step(0, 0, 1, 0, got);
        step(0, 0, 0, 1, got);
        step(1, 2, 1, 0, got);
        for (int k = 0; k < CMAX + 6; k++) step(0, 0, 0, 0, got);
        while (m_cur < NR - 1) begin
            step(0, 0, 0, 0, got);
            step(1, 0, 0, 0, got);
        end

        chk("R8", "prop_valid low when done", prop_valid, 0);
        dec_valid = 1;
        dec_accept = 1;
        repeat (2) @(negedge clk);
        dec_valid = 0;
        dec_accept = 0;
        repeat (3) @(negedge clk);
        chk("R8", "still done", done, 1);
        chk("R8", "prop_valid stays low", prop_valid, 0);
        chk("R8", "row held", cur_row, NR - 1);
        push(NR - 1, "R8");
        drain();

        do_start({8'h9C, 8'd100, 8'd1, 8'hFF});
        step(1, 0, 0, 0, got);
        step(0, 0, 0, 0, got);

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule